// File: doc/BRIEF.md
# Waveform Table Fill Engine

This block fills a 256-entry, 8-bit waveform table through a plain write port. A one-cycle start strobe captures a shape code, an amplitude and an offset. The engine then emits one write per clock for addresses 0 through 255 in ascending order. Each data byte is a normalised shape value, scaled by the amplitude, raised by the offset and limited to 255. A single-cycle done pulse follows the final write.

The normalised value is an unsigned fraction with eight fractional bits, ranging 0..256, where 256 stands for 1.0. The product with the amplitude is truncated, and no floating point appears in the hardware. The sine shape is read from a quarter-wave table of 65 entries. That table is computed when the design is elaborated, and the engine mirrors and inverts it to cover the other three quarters. A typical use is to fill the spare half of a double-buffered sample memory while the other half keeps playing, and then swap the halves once done is seen.

Top module: `wave_fill`

## Requirements
- R1: After reset, and until a start is accepted, `wr_en` and `done` are both 0.
- R2: A start seen while idle produces exactly 256 writes on consecutive clocks, with `wr_en` high. The first write comes in the cycle after start is sampled, and the addresses run 0,1,...,255.
- R3: `done` is high for exactly one cycle: the cycle right after the write to address 255. `wr_en` is low in that cycle.
- R4: Shape, amplitude and offset are captured on the accepted start. A start while writes are in progress, including the cycle of the last write, is ignored. Input changes during a fill do not alter the data written.
- R5: Each data byte is min(255, floor(n*amplitude/256) + offset), where n is the normalised value in 0..256 for index i.
- R6: Shape code 1 (square): n = 256 for i < 128 and n = 0 otherwise.
- R7: Shape code 2 (triangle): n = 2i for i < 128 and n = 512 - 2i for i >= 128.
- R8: Shape code 3 (sawtooth): n = i, so it never reaches 256.
- R9: Shape code 0 (sine): n = round(128 + 128*sin(2*pi*i/256)), spanning 0..256.
- R10: Shape code 4 (DC), and the unused codes 5 to 7, give n = 0, so every entry equals the offset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle request to begin a fill |
| shape | input | 3 | Shape code, sampled on an accepted start |
| amp | input | 8 | Amplitude, sampled on an accepted start |
| offset | input | 8 | Offset, sampled on an accepted start |
| wr_en | output | 1 | Table write enable |
| wr_addr | output | 8 | Table write address |
| wr_data | output | 8 | Table write data |
| done | output | 1 | One-cycle pulse after the last write |

## Verification
Every shape code is run at least once through a full fill, and the amplitude and offset vary from run to run. Full-scale sine separates the mirrored and inverted quarters of the sine table. Square at half amplitude with an offset, and triangle at amplitude 200, expose truncation and a wrong scaling shift. A triangle whose offset drives the top half past 255 separates clamping from wraparound. A zero-amplitude DC fill and a fill with an unused code show that the offset passes through alone. One fill changes its inputs right after start and pulses start twice while busy, once during the last write. Any extra or altered write from that fill shows up as an unexpected item in the scoreboard.

// File: rtl/wave_fill.sv
`timescale 1ns/1ps
module wave_fill #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        shape,
  input  logic [DATA_W-1:0] amp,
  input  logic [DATA_W-1:0] offset,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              done
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int QTR   = DEPTH / 4;
  localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);
  localparam logic [ADDR_W:0]   MID  = (ADDR_W+1)'(DEPTH / 2);

  localparam logic [2:0] SH_SINE = 3'd0;
  localparam logic [2:0] SH_SQR  = 3'd1;
  localparam logic [2:0] SH_TRI  = 3'd2;
  localparam logic [2:0] SH_SAW  = 3'd3;

  function automatic int quarter_sine(int k);
    real a;
    a = (DEPTH / 2.0) * $sin(2.0 * 3.14159265358979 * k / DEPTH);
    return $rtoi(a + 0.5);
  endfunction

  logic [ADDR_W:0] qtab [0:QTR];
  for (genvar k = 0; k <= QTR; k++) begin : g_quarter
    localparam logic [ADDR_W:0] QV = (ADDR_W+1)'(quarter_sine(k));
    assign qtab[k] = QV;
  end

  logic              busy;
  logic [ADDR_W-1:0] idx;
  logic [2:0]        shape_q;
  logic [DATA_W-1:0] amp_q, off_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      idx     <= '0;
      shape_q <= '0;
      amp_q   <= '0;
      off_q   <= '0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        idx <= idx + 1'b1;
        if (idx == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        busy    <= 1'b1;
        idx     <= '0;
        shape_q <= shape;
        amp_q   <= amp;
        off_q   <= offset;
      end
    end
  end

  logic [ADDR_W-2:0] qi;
  logic [ADDR_W:0]   sine_n, down, norm;
  logic [ADDR_W+DATA_W:0] prod;
  logic [DATA_W:0]   sum;

  assign qi     = idx[ADDR_W-2] ? (ADDR_W-1)'(QTR) - {1'b0, idx[ADDR_W-3:0]}
                                : {1'b0, idx[ADDR_W-3:0]};
  assign sine_n = idx[ADDR_W-1] ? MID - qtab[qi] : MID + qtab[qi];
  assign down   = (ADDR_W+1)'(DEPTH) - {1'b0, idx};

  always_comb begin
    case (shape_q)
      SH_SINE: norm = sine_n;
      SH_SQR:  norm = idx[ADDR_W-1] ? '0 : (ADDR_W+1)'(DEPTH);
      SH_TRI:  norm = idx[ADDR_W-1] ? {down[ADDR_W-1:0], 1'b0} : {idx[ADDR_W-2:0], 1'b0};
      SH_SAW:  norm = {1'b0, idx};
      default: norm = '0;
    endcase
  end

  assign prod    = (ADDR_W+DATA_W+1)'(norm) * (ADDR_W+DATA_W+1)'(amp_q);
  assign sum     = (DATA_W+1)'(prod >> ADDR_W) + {1'b0, off_q};
  assign wr_data = sum[DATA_W] ? '1 : sum[DATA_W-1:0];
  assign wr_en   = busy;
  assign wr_addr = idx;

  assert_first_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (wr_en && wr_addr == '0));
  assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && $past(wr_en)) |-> (wr_addr == ADDR_W'($past(wr_addr) + 1'b1)));
  assert_done_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(wr_en && wr_addr == LAST));
  assert_done_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, wr_en}));
  assert_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> !(wr_en && wr_addr == '0));
  assert_offset_floor_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_data >= off_q));
endmodule

// File: tb/wave_fill_test.sv
`timescale 1ns/1ps
module wave_fill_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] shape = '0;
  logic [7:0] amp = '0, offset = '0;
  logic       wr_en, done;
  logic [7:0] wr_addr, wr_data;

  int    n_tests = 0;
  int    n_fail = 0;
  int    expq[$];
  string cur_tag = "R2";

  wave_fill uut (.clk(clk), .rst_n(rst_n), .start(start), .shape(shape), .amp(amp),
                 .offset(offset), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
                 .done(done));

  always #10 clk = ~clk;

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int norm_of(int sh, int i);
    case (sh)
      0: return $rtoi($floor(128.0 + 128.0 * $sin(2.0 * 3.14159265358979 * i / 256.0) + 0.5));
      1: return (i < 128) ? 256 : 0;
      2: return (i < 128) ? 2 * i : 512 - 2 * i;
      3: return i;
      default: return 0;
    endcase
  endfunction

  function automatic int entry_of(int sh, int a, int o, int i);
    int v;
    v = (norm_of(sh, i) * a) / 256 + o;
    return (v > 255) ? 255 : v;
  endfunction

  always @(negedge clk) begin
    if (wr_en) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R4 unexpected write", wr_addr, -1);
      end else begin
        int e;
        e = expq.pop_front();
        chk(wr_addr == e[15:8], {cur_tag, " R2 address"}, wr_addr, e[15:8]);
        chk(wr_data == e[7:0], {cur_tag, " R5 data"}, wr_data, e[7:0]);
      end
    end
  end

  task automatic fill(int sh, int a, int o, string tag, bit disturb);
    cur_tag = tag;
    for (int i = 0; i < 256; i++) expq.push_back((i << 8) | entry_of(sh, a, o, i));
    @(negedge clk);
    start = 1'b1; shape = 3'(sh); amp = 8'(a); offset = 8'(o);
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      shape = 3'd3; amp = 8'd17; offset = 8'd99;
    end
    for (int k = 0; k < 255; k++) begin
      @(negedge clk);
      start = disturb && (k == 100 || k == 254);
    end
    @(negedge clk);
    start = 1'b0;
    chk(done == 1'b1, {tag, " R3 done after last"}, done, 1);
    chk(wr_en == 1'b0, {tag, " R3 no write with done"}, wr_en, 0);
    chk(expq.size() == 0, {tag, " R2 256 writes"}, expq.size(), 0);
    @(negedge clk);
    chk(done == 1'b0, {tag, " R3 done single cycle"}, done, 0);
    chk(wr_en == 1'b0, {tag, " R4 no restart"}, wr_en, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0, "R1 wr_en in reset", wr_en, 0);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(wr_en == 1'b0 && done == 1'b0, "R1 idle after reset", {wr_en, done}, 0);
    fill(0, 255, 0,   "R9 sine full", 1'b0);
    fill(1, 128, 64,  "R6 square", 1'b0);
    fill(2, 200, 50,  "R7 triangle with disturbance R4", 1'b1);
    fill(2, 255, 200, "R5 clamp triangle", 1'b0);
    fill(3, 255, 0,   "R8 sawtooth", 1'b0);
    fill(0, 100, 20,  "R9 sine scaled", 1'b0);
    fill(4, 0, 128,   "R10 dc", 1'b0);
    fill(7, 255, 30,  "R10 unused code", 1'b0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(20 * 50000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule